// File: doc/BRIEF.md
# Lock-Step Pair Result Selector

This block sits between four (or any multiple of four) redundant processor cores and the consumer of their results. Adjacent cores are bound into fixed lock-step components: core 2k and core 2k+1 form component k, and each component has its own comparator. In every evaluation round the selector checks each healthy component, forwards the result of a component whose two cores agree, and keeps a per-component record of mismatches. A mismatch that repeats on the same task marks that component as permanently failed.

While at least two components are healthy, a disagreeing component is masked by the matched result of another one. Once only one healthy component is left, a mismatch on it can no longer be masked this way. The selector then raises a re-execution request for the same task on that component. If the repeated run agrees, the result is forwarded and the fault is treated as transient. If it disagrees again, the component is failed and the system is declared down until reset. Task scheduling and the cores themselves are outside the block.

Top module: `lockstep_pair_selector`

## Requirements
- R1: After reset, result_valid, reexec_req and sys_down are 0, and every bit of comp_failed and comp_suspect is 0.
- R2: A round is any clock cycle with at least one core_valid bit high. Component k (cores 2k and 2k+1) agrees when both of its valid bits are high and both data words are equal. A component with a missing valid bit counts as disagreeing. One cycle after a round that has an agreeing healthy component, result_valid pulses for one cycle, with result_task equal to that round's task_id.
- R3: If several healthy components agree, result_data is the word of the lowest-numbered one. If a healthy component disagrees while another agrees, the agreeing component's word is forwarded and no re-execution or down is raised.
- R4: A disagreeing healthy component sets its comp_suspect bit, and an agreeing round clears it. A second consecutive disagreement with the same task_id sets comp_failed for that component permanently and clears its suspect bit. A disagreement on a different task_id only restarts the count. failed and suspect are never both set.
- R5: The core words and valid bits of a failed component have no effect on result selection.
- R6: When exactly one component is healthy and it disagrees, reexec_req goes high from the next cycle and stays high until that component's next round, with reexec_task equal to the task_id. No result is forwarded.
- R7: An agreeing round while reexec_req is high forwards the result, drops reexec_req in the same cycle that result_valid rises, and clears the component's suspect bit.
- R8: A disagreeing round while reexec_req is high sets sys_down and the component's failed bit, and drops reexec_req.
- R9: A round in which two or more components are healthy and none agrees sets sys_down.
- R10: sys_down stays high until reset. While it is high, rounds forward nothing and raise no re-execution. Reset clears it together with all component status.
- R11: result_valid is never high together with reexec_req or sys_down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_valid | input | NUM_CORES | Per-core result strobe |
| core_data | input | NUM_CORES*DATA_W | Per-core result words, core i at bits i*DATA_W upward |
| task_id | input | TASK_W | Task identifier of the current round |
| result_valid | output | 1 | One-cycle pulse for a forwarded matched result |
| result_data | output | DATA_W | Forwarded result word |
| result_task | output | TASK_W | Task of the forwarded result |
| reexec_req | output | 1 | Re-execution of reexec_task on the last healthy component is requested |
| reexec_task | output | TASK_W | Task to re-execute |
| sys_down | output | 1 | Unmasked fault; held until reset |
| comp_failed | output | NUM_COMP | Per-component permanent failure |
| comp_suspect | output | NUM_COMP | Per-component single recorded mismatch |

## Verification
The selection path is exercised with both components agreeing on different words, which shows the lowest-index priority. It is also exercised with one component missing a valid bit and with one component carrying differing words, which tells masking apart from escalation. Repeated mismatches on a component are given first with a changed task_id and then with the same one, which separates a restarted suspect count from a permanent failure. With one component left, a mismatch followed by an agreeing repeat, and a mismatch followed by a disagreeing repeat, separate transient recovery from system-down. A round in which both healthy components disagree, and rounds given after down, confirm the down condition and that it holds.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    // Outcome of one evaluation round, chosen by the control path.
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_FORWARD = 2'd1,
        ACT_REEXEC  = 2'd2,
        ACT_DOWN    = 2'd3
    } round_action_t;

    // Per-component health record.
    typedef struct packed {
        logic failed;
        logic suspect;
    } comp_state_t;

    // Decide what a round does from the comparator and health summary.
    function automatic round_action_t decide_action(
        input logic round,
        input logic down,
        input logic any_agree,
        input logic pending,
        input logic single_left
    );
        if (!round || down)
            return ACT_IDLE;
        else if (any_agree)
            return ACT_FORWARD;
        else if (!pending && single_left)
            return ACT_REEXEC;
        else
            return ACT_DOWN;
    endfunction

endpackage

// File: rtl/lsp_pair_cmp.sv
module lsp_pair_cmp #(
    parameter int DATA_W = 32
) (
    input  logic              valid_a,
    input  logic              valid_b,
    input  logic [DATA_W-1:0] data_a,
    input  logic [DATA_W-1:0] data_b,
    output logic              agree
);
    // Both cores must report, and report the same word.
    assign agree = valid_a & valid_b & (data_a == data_b);
endmodule

// File: rtl/lsp_comp_health.sv
module lsp_comp_health
    import lsp_pkg::*;
#(
    parameter int TASK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eval_en,
    input  logic              disagree,
    input  logic [TASK_W-1:0] task_id,
    output comp_state_t       state
);
    comp_state_t       st_q;
    logic [TASK_W-1:0] last_task_q;
    logic              repeat_hit;

    assign repeat_hit = st_q.suspect && (last_task_q == task_id);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '0;
            last_task_q <= '0;
        end else if (eval_en && !st_q.failed) begin
            if (disagree) begin
                if (repeat_hit) begin
                    st_q.failed  <= 1'b1;
                    st_q.suspect <= 1'b0;
                end else begin
                    st_q.suspect <= 1'b1;
                    last_task_q  <= task_id;
                end
            end else begin
                st_q.suspect <= 1'b0;
            end
        end
    end

    assign state = st_q;
endmodule

// File: rtl/lsp_result_pick.sv
module lsp_result_pick #(
    parameter int NUM_COMP = 2,
    parameter int DATA_W   = 32
) (
    input  logic [NUM_COMP-1:0]        agree,
    input  logic [NUM_COMP*DATA_W-1:0] words,
    output logic                       any_agree,
    output logic [DATA_W-1:0]          word_out
);
    // Lowest-index agreeing component wins.
    always_comb begin
        any_agree = |agree;
        word_out  = '0;
        for (int k = NUM_COMP - 1; k >= 0; k--) begin
            if (agree[k])
                word_out = words[k*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/lockstep_pair_selector.sv
module lockstep_pair_selector
    import lsp_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32,
    parameter int TASK_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CORES-1:0]          core_valid,
    input  logic [NUM_CORES*DATA_W-1:0]   core_data,
    input  logic [TASK_W-1:0]             task_id,
    output logic                          result_valid,
    output logic [DATA_W-1:0]             result_data,
    output logic [TASK_W-1:0]             result_task,
    output logic                          reexec_req,
    output logic [TASK_W-1:0]             reexec_task,
    output logic                          sys_down,
    output logic [NUM_CORES/2-1:0]        comp_failed,
    output logic [NUM_CORES/2-1:0]        comp_suspect
);
    // NUM_CORES is expected to be a multiple of four.
    localparam int NUM_COMP = NUM_CORES / 2;

    logic [NUM_COMP-1:0]        agree_raw;
    logic [NUM_COMP-1:0]        agree_ok;
    logic [NUM_COMP-1:0]        healthy;
    logic [NUM_COMP*DATA_W-1:0] comp_words;
    comp_state_t                comp_st [NUM_COMP];

    logic              round;
    logic              eval_en;
    logic              any_agree;
    logic              single_left;
    logic [DATA_W-1:0] pick_word;
    round_action_t     act;

    logic              fwd_q;
    logic [DATA_W-1:0] data_q;
    logic [TASK_W-1:0] task_q;
    logic              pend_q;
    logic [TASK_W-1:0] retask_q;
    logic              down_q;

    assign round   = |core_valid;
    assign eval_en = round & ~down_q;

    for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
        lsp_pair_cmp #(.DATA_W(DATA_W)) u_cmp (
            .valid_a (core_valid[2*k]),
            .valid_b (core_valid[2*k+1]),
            .data_a  (core_data[(2*k)*DATA_W +: DATA_W]),
            .data_b  (core_data[(2*k+1)*DATA_W +: DATA_W]),
            .agree   (agree_raw[k])
        );

        lsp_comp_health #(.TASK_W(TASK_W)) u_health (
            .clk      (clk),
            .rst      (rst),
            .eval_en  (eval_en),
            .disagree (~agree_raw[k]),
            .task_id  (task_id),
            .state    (comp_st[k])
        );

        assign comp_words[k*DATA_W +: DATA_W] = core_data[(2*k)*DATA_W +: DATA_W];
        assign healthy[k]      = ~comp_st[k].failed;
        assign comp_failed[k]  = comp_st[k].failed;
        assign comp_suspect[k] = comp_st[k].suspect;
    end

    assign agree_ok    = agree_raw & healthy;
    assign single_left = ($countones(healthy) == 1);

    lsp_result_pick #(.NUM_COMP(NUM_COMP), .DATA_W(DATA_W)) u_pick (
        .agree     (agree_ok),
        .words     (comp_words),
        .any_agree (any_agree),
        .word_out  (pick_word)
    );

    assign act = decide_action(round, down_q, any_agree, pend_q, single_left);

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_q    <= 1'b0;
            data_q   <= '0;
            task_q   <= '0;
            pend_q   <= 1'b0;
            retask_q <= '0;
            down_q   <= 1'b0;
        end else begin
            fwd_q <= 1'b0;
            case (act)
                ACT_FORWARD: begin
                    fwd_q  <= 1'b1;
                    data_q <= pick_word;
                    task_q <= task_id;
                    pend_q <= 1'b0;
                end
                ACT_REEXEC: begin
                    pend_q   <= 1'b1;
                    retask_q <= task_id;
                end
                ACT_DOWN: begin
                    down_q <= 1'b1;
                    pend_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign result_valid = fwd_q;
    assign result_data  = data_q;
    assign result_task  = task_q;
    assign reexec_req   = pend_q;
    assign reexec_task  = retask_q;
    assign sys_down     = down_q;
endmodule

// File: rtl/lockstep_pair_selector_chk.sv
module lockstep_pair_selector_chk #(
    parameter int NUM_COMP = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                result_valid,
    input logic                reexec_req,
    input logic                sys_down,
    input logic [NUM_COMP-1:0] comp_failed,
    input logic [NUM_COMP-1:0] comp_suspect
);
    assert_fwd_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (!reexec_req && !sys_down));

    assert_down_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        sys_down |=> sys_down);

    assert_down_no_reexec_R8: assert property (@(posedge clk) disable iff (rst)
        sys_down |-> !reexec_req);

    assert_failed_permanent_R4: assert property (@(posedge clk) disable iff (rst)
        !sys_down |=> ((comp_failed & $past(comp_failed)) == $past(comp_failed)));

    assert_state_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        (comp_failed != '0) |-> ((comp_failed & comp_suspect) == '0));

    assert_reexec_single_R6: assert property (@(posedge clk) disable iff (rst)
        reexec_req |-> ($countones(~comp_failed) == 1));
endmodule

bind lockstep_pair_selector lockstep_pair_selector_chk #(.NUM_COMP(NUM_CORES/2)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .result_valid (result_valid),
    .reexec_req   (reexec_req),
    .sys_down     (sys_down),
    .comp_failed  (comp_failed),
    .comp_suspect (comp_suspect)
);

// File: tb/lockstep_pair_selector_bench.sv
module lockstep_pair_selector_bench;
    localparam int NC = 4;
    localparam int DW = 32;
    localparam int TW = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NC-1:0]     core_valid = '0;
    logic [NC*DW-1:0]  core_data = '0;
    logic [TW-1:0]     task_id = '0;
    logic              result_valid;
    logic [DW-1:0]     result_data;
    logic [TW-1:0]     result_task;
    logic              reexec_req;
    logic [TW-1:0]     reexec_task;
    logic              sys_down;
    logic [NC/2-1:0]   comp_failed;
    logic [NC/2-1:0]   comp_suspect;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    lockstep_pair_selector #(.NUM_CORES(NC), .DATA_W(DW), .TASK_W(TW)) u_lockstep_pair_selector (
        .clk(clk), .rst(rst), .core_valid(core_valid), .core_data(core_data),
        .task_id(task_id), .result_valid(result_valid), .result_data(result_data),
        .result_task(result_task), .reexec_req(reexec_req), .reexec_task(reexec_task),
        .sys_down(sys_down), .comp_failed(comp_failed), .comp_suspect(comp_suspect)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one round; outputs are sampled just after the capturing edge.
    task automatic do_round(input logic [31:0] w0, w1, w2, w3,
                            input logic [3:0] vm, input logic [TW-1:0] tid);
        @(negedge clk);
        core_data  = {w3, w2, w1, w0};
        core_valid = vm;
        task_id    = tid;
        @(posedge clk);
        #1;
        core_valid = '0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        core_valid = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        apply_reset();
        chk("R1 result_valid", 32'(result_valid), 0);
        chk("R1 reexec_req", 32'(reexec_req), 0);
        chk("R1 sys_down", 32'(sys_down), 0);
        chk("R1 comp_failed", 32'(comp_failed), 0);
        chk("R1 comp_suspect", 32'(comp_suspect), 0);
    endtask

    task automatic t_priority();
        do_round(32'h11, 32'h11, 32'h22, 32'h22, 4'b1111, 4'd1);
        chk("R2 result_valid", 32'(result_valid), 1);
        chk("R3 lowest index word", result_data, 32'h11);
        chk("R2 result_task", 32'(result_task), 1);
        idle_cycle();
        chk("R2 single pulse", 32'(result_valid), 0);
    endtask

    task automatic t_missing_valid();
        do_round(32'h33, 32'h33, 32'h44, 32'h44, 4'b1101, 4'd2);
        chk("R2 missing valid masked", result_data, 32'h44);
        chk("R3 no reexec on mask", 32'(reexec_req), 0);
        chk("R4 suspect set", 32'(comp_suspect), 32'b01);
        do_round(32'h55, 32'h55, 32'h55, 32'h55, 4'b1111, 4'd2);
        chk("R4 suspect cleared", 32'(comp_suspect), 0);
    endtask

    task automatic t_permanent();
        do_round(32'h1, 32'h2, 32'h66, 32'h66, 4'b1111, 4'd3);
        chk("R3 masked word", result_data, 32'h66);
        do_round(32'h1, 32'h2, 32'h77, 32'h77, 4'b1111, 4'd4);
        chk("R4 new task restarts", 32'(comp_failed), 0);
        chk("R4 still suspect", 32'(comp_suspect), 32'b01);
        do_round(32'h1, 32'h2, 32'h78, 32'h78, 4'b1111, 4'd4);
        chk("R4 failed set", 32'(comp_failed), 32'b01);
        chk("R4 suspect cleared on fail", 32'(comp_suspect), 0);
        chk("R3 masked on fail round", result_data, 32'h78);
    endtask

    task automatic t_ignored();
        do_round(32'h9, 32'h9, 32'h88, 32'h88, 4'b1111, 4'd5);
        chk("R5 failed comp ignored", result_data, 32'h88);
        do_round(32'hA, 32'hB, 32'h99, 32'h99, 4'b1111, 4'd5);
        chk("R5 garbage ignored", result_data, 32'h99);
        chk("R5 no down", 32'(sys_down), 0);
        chk("R5 no reexec", 32'(reexec_req), 0);
    endtask

    task automatic t_reexec_ok();
        do_round(32'h0, 32'h0, 32'hC1, 32'hC2, 4'b1111, 4'd6);
        chk("R6 reexec_req", 32'(reexec_req), 1);
        chk("R6 reexec_task", 32'(reexec_task), 6);
        chk("R6 no result", 32'(result_valid), 0);
        chk("R6 suspect", 32'(comp_suspect), 32'b10);
        idle_cycle();
        chk("R6 request held", 32'(reexec_req), 1);
        do_round(32'h0, 32'h0, 32'hC3, 32'hC3, 4'b1111, 4'd6);
        chk("R7 result_valid", 32'(result_valid), 1);
        chk("R7 result_data", result_data, 32'hC3);
        chk("R7 reexec dropped", 32'(reexec_req), 0);
        chk("R7 suspect cleared", 32'(comp_suspect), 0);
    endtask

    task automatic t_reexec_fail();
        do_round(32'h0, 32'h0, 32'hD1, 32'hD2, 4'b1111, 4'd7);
        chk("R6 reexec again", 32'(reexec_req), 1);
        do_round(32'h0, 32'h0, 32'hD1, 32'hD3, 4'b1111, 4'd7);
        chk("R8 sys_down", 32'(sys_down), 1);
        chk("R8 both failed", 32'(comp_failed), 32'b11);
        chk("R8 reexec dropped", 32'(reexec_req), 0);
        do_round(32'hE, 32'hE, 32'hE, 32'hE, 4'b1111, 4'd8);
        chk("R10 no result while down", 32'(result_valid), 0);
        chk("R10 down held", 32'(sys_down), 1);
        apply_reset();
        chk("R10 reset clears down", 32'(sys_down), 0);
        chk("R10 reset clears failed", 32'(comp_failed), 0);
    endtask

    task automatic t_both_disagree();
        do_round(32'h1, 32'h2, 32'h3, 32'h4, 4'b1111, 4'd9);
        chk("R9 sys_down", 32'(sys_down), 1);
        chk("R9 no result", 32'(result_valid), 0);
        chk("R9 no reexec", 32'(reexec_req), 0);
    endtask

    initial begin
        t_reset();
        t_priority();
        t_missing_valid();
        t_permanent();
        t_ignored();
        t_reexec_ok();
        t_reexec_fail();
        t_both_disagree();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule